// File: doc/BRIEF.md
# Trailing-bit masking for a byte-wide serial transmitter

This block lets a transmitter that moves whole words emit a stream whose length is not a multiple of the word size. Software writes words into a one-word transmit buffer. Each write also latches a tail-enable bit that marks whether the word is the final one of a stream. The shifter sends each word out one bit per shift tick, most significant bit first.

While a final word is on the wire, a small counter counts the shift ticks and compares the count with a programmed value. When the count equals that value, a mask signal rises. From then on every remaining bit of the word is forced to 0 on the serial output. The mask stays raised after the word ends, until the next word is loaded or the shifter is deactivated. Masking works only in the two plain synchronous modes. In the two link-style modes the final word always goes out in full.

Top module: `tail_mask_tx`

## Requirements
- R1: After reset, with nothing written, `ser_out` and `mask` are both 0.
- R2: A loaded word appears on `ser_out` most significant bit first. Bit 7 is presented after the load, and each `shift_tick` advances to the next lower bit. After eight ticks the shifter is idle and drives 0.
- R3: A word written with `tail_off` = 1 is not a final word. All eight of its bits go out unmasked, and `mask` stays 0.
- R4: A word written with `tail_off` = 0 is a final word. In a synchronous mode (`mode` 2'b11 or 2'b10), the first `cmp_val` bits of that word are sent unchanged. `mask` is 1 and `ser_out` is 0 for every later bit of the word.
- R5: With `cmp_val` = 0, `mask` rises as soon as the final word is loaded, and every bit of that word is blanked.
- R6: With `cmp_val` of 8 or more, the final word goes out unmasked and `mask` stays 0.
- R7: In the link modes (`mode` 2'b01 or 2'b00), a final word goes out unmasked and `mask` stays 0.
- R8: The tick counter advances only while a final word is being shifted. Non-final words sent before the final word do not move the point at which the mask rises.
- R9: While `active` is 0, the shifter, the counter and the mask are cleared, and `ser_out` and `mask` read 0. This still holds after `active` returns to 1 with the buffer empty.
- R10: Once `mask` has risen, it stays 1 after the final word has finished, with `ser_out` at 0. It is released when the next word is loaded or when the shifter is deactivated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| active | input | 1 | Shifter enable; 0 clears the shifter, counter and mask |
| mode | input | 2 | 11/10 synchronous modes, 01/00 link modes |
| tail_off | input | 1 | Latched with each write: 0 marks the word as final, 1 sends it in full |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | WORD_W | Word to transmit |
| shift_tick | input | 1 | One-cycle pulse that advances the shifter by one bit |
| cmp_val | input | CNT_W | Number of leading bits of the final word left unmasked |
| ser_out | output | 1 | Serial output after masking |
| mask | output | 1 | High while trailing bits are blanked |

## Verification
The hardest case to reach from the ports is a final word that follows ordinary words. Here the counter must stay idle through the earlier words and start from zero on the final one. A mistake would show only as a mask edge at the wrong bit. The bench therefore sends a plain word and then a final word with the same compare value, and checks the output bit by bit on both. It also drops `active` in the middle of a final word and then restarts, to show that no count or mask survives the break.

// File: rtl/tm_pkg.sv
package tm_pkg;
   typedef enum logic [1:0] {
      M_LINK8    = 2'b00,
      M_LINK9    = 2'b01,
      M_SYNC_FAL = 2'b10,
      M_SYNC_RIS = 2'b11
   } tm_mode_e;

   function automatic logic is_sync(input logic [1:0] m);
      return (m == M_SYNC_RIS) || (m == M_SYNC_FAL);
   endfunction
endpackage

// File: rtl/tm_txbuf.sv
module tm_txbuf #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              tail_off,
   input  logic              take,
   output logic              full,
   output logic [WORD_W-1:0] data_q,
   output logic              last_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full   <= 1'b0;
         data_q <= '0;
         last_q <= 1'b0;
      end else if (wr_en) begin
         full   <= 1'b1;
         data_q <= wr_data;
         last_q <= ~tail_off;
      end else if (take) begin
         full   <= 1'b0;
      end
   end
endmodule

// File: rtl/tm_shifter.sv
module tm_shifter #(
   parameter int WORD_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              full,
   input  logic [WORD_W-1:0] data_in,
   input  logic              last_in,
   input  logic              shift_tick,
   output logic              take,
   output logic              busy,
   output logic              step,
   output logic              cur_bit,
   output logic              cur_last
);
   localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [BIT_W-1:0] LAST_POS = BIT_W'(WORD_W - 1);

   logic [WORD_W-1:0] sreg;
   logic [WORD_W-1:0] sreg_next;
   logic [BIT_W-1:0]  pos;

   assign take = active & ~busy & full;
   assign step = active & busy & shift_tick;

   generate
      if (MSB_FIRST) begin : g_msb
         assign cur_bit   = sreg[WORD_W-1];
         assign sreg_next = {sreg[WORD_W-2:0], 1'b0};
      end else begin : g_lsb
         assign cur_bit   = sreg[0];
         assign sreg_next = {1'b0, sreg[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg     <= '0;
         pos      <= '0;
         busy     <= 1'b0;
         cur_last <= 1'b0;
      end else if (!active) begin
         pos      <= '0;
         busy     <= 1'b0;
         cur_last <= 1'b0;
      end else if (take) begin
         sreg     <= data_in;
         pos      <= '0;
         busy     <= 1'b1;
         cur_last <= last_in;
      end else if (step) begin
         sreg <= sreg_next;
         if (pos == LAST_POS) begin
            busy <= 1'b0;
            pos  <= '0;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tm_maskctl.sv
module tm_maskctl #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             sync_mode,
   input  logic             load,
   input  logic             busy,
   input  logic             cur_last,
   input  logic             step,
   input  logic [CNT_W-1:0] cmp_val,
   output logic             mask
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt;
   logic             mask_q;
   logic             armed;
   logic             hit;

   assign armed = busy & cur_last & sync_mode;
   assign hit   = armed & (cnt == cmp_val);
   assign mask  = mask_q | hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         mask_q <= 1'b0;
      end else if (!active || load) begin
         cnt    <= '0;
         mask_q <= 1'b0;
      end else begin
         if (hit)
            mask_q <= 1'b1;
         if (step && armed && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tail_mask_tx.sv
module tail_mask_tx #(
   parameter int WORD_W    = 8,
   parameter int CNT_W     = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [1:0]        mode,
   input  logic              tail_off,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              shift_tick,
   input  logic [CNT_W-1:0]  cmp_val,
   output logic              ser_out,
   output logic              mask
);
   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("tail_mask_tx: WORD_W must be at least 2");
      end
      if ((2 ** CNT_W) <= WORD_W) begin : g_bad_cnt
         $error("tail_mask_tx: CNT_W too narrow to count a full word");
      end
   endgenerate

   logic              full;
   logic [WORD_W-1:0] buf_data;
   logic              buf_last;
   logic              take;
   logic              busy;
   logic              step;
   logic              cur_bit;
   logic              cur_last;
   logic              sync_mode;

   assign sync_mode = tm_pkg::is_sync(mode);

   tm_txbuf #(.WORD_W(WORD_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tail_off(tail_off), .take(take), .full(full),
      .data_q(buf_data), .last_q(buf_last)
   );

   tm_shifter #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shf (
      .clk(clk), .rst_n(rst_n), .active(active), .full(full),
      .data_in(buf_data), .last_in(buf_last), .shift_tick(shift_tick),
      .take(take), .busy(busy), .step(step), .cur_bit(cur_bit),
      .cur_last(cur_last)
   );

   tm_maskctl #(.CNT_W(CNT_W)) u_msk (
      .clk(clk), .rst_n(rst_n), .active(active), .sync_mode(sync_mode),
      .load(take), .busy(busy), .cur_last(cur_last), .step(step),
      .cmp_val(cmp_val), .mask(mask)
   );

   assign ser_out = busy & ~mask & cur_bit;
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
   parameter int WORD_W = 8,
   parameter int CNT_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             active,
   input logic             mode_hi,
   input logic [CNT_W-1:0] cmp_val,
   input logic             take,
   input logic             ser_out,
   input logic             mask
);
   p_blank_when_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mask |-> !ser_out);

   p_no_mask_big_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mask) |-> (int'(cmp_val) < WORD_W));

   p_sync_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mask) |-> mode_hi);

   p_idle_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!mask && !ser_out));

   p_mask_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask && active && !take) |=> mask);
endmodule

bind tail_mask_tx tm_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .active(active), .mode_hi(mode[1]),
   .cmp_val(cmp_val), .take(take), .ser_out(ser_out), .mask(mask)
);

// File: tb/tail_mask_tx_bench.sv
module tail_mask_tx_bench;
   typedef struct {
      logic  ser;
      logic  msk;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       active = 1'b0;
   logic [1:0] mode = 2'b11;
   logic       tail_off = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       shift_tick = 1'b0;
   logic [3:0] cmp_val = '0;
   logic       ser_out;
   logic       mask;
   logic       sample_req = 1'b0;

   int   n_checks = 0;
   int   n_fail = 0;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   tail_mask_tx u_tail_mask_tx (
      .clk(clk), .rst_n(rst_n), .active(active), .mode(mode),
      .tail_off(tail_off), .wr_en(wr_en), .wr_data(wr_data),
      .shift_tick(shift_tick), .cmp_val(cmp_val),
      .ser_out(ser_out), .mask(mask)
   );

   always @(posedge clk) begin
      if (sample_req) begin
         #2;
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard empty: ser=%0b mask=%0b", ser_out, mask);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (ser_out !== e.ser || mask !== e.msk) begin
               n_fail++;
               $display("FAIL %s: ser=%0b mask=%0b expected ser=%0b mask=%0b",
                        e.tag, ser_out, mask, e.ser, e.msk);
            end
         end
      end
   end

   task automatic expect_now(input logic s, input logic m, input string tag);
      exp_q.push_back('{s, m, tag});
      @(negedge clk) sample_req = 1'b1;
      @(negedge clk) sample_req = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk) shift_tick = 1'b1;
      @(negedge clk) shift_tick = 1'b0;
   endtask

   task automatic write_word(input logic [7:0] d, input logic off);
      @(negedge clk);
      wr_data  = d;
      tail_off = off;
      wr_en    = 1'b1;
      @(negedge clk) wr_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic run_word(input logic [7:0] d, input bit last, input int cmp,
                           input logic [1:0] m, input int nbits, input string tag);
      bit masked;
      mode    = m;
      cmp_val = 4'(cmp);
      write_word(d, !last);
      for (int i = 0; i < nbits; i++) begin
         masked = last && m[1] && (i >= cmp);
         expect_now(masked ? 1'b0 : d[7-i], masked, tag);
         pulse_tick();
      end
      if (nbits == 8)
         expect_now(1'b0, last && m[1] && (cmp < 8), tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk) active = 1'b1;
      expect_now(1'b0, 1'b0, "R1");
      run_word(8'hA5, 0, 3, 2'b11, 8, "R2");
      run_word(8'h3C, 0, 5, 2'b11, 8, "R3");
      run_word(8'hC7, 1, 5, 2'b11, 8, "R8");
      run_word(8'hB6, 1, 3, 2'b10, 8, "R4");
      expect_now(1'b0, 1'b1, "R10");
      run_word(8'hFF, 1, 0, 2'b10, 8, "R5");
      run_word(8'h81, 1, 8, 2'b11, 8, "R6");
      run_word(8'h6B, 1, 15, 2'b11, 8, "R6");
      run_word(8'hE1, 1, 2, 2'b01, 8, "R7");
      run_word(8'h9D, 1, 2, 2'b00, 8, "R7");
      run_word(8'h5A, 1, 2, 2'b11, 4, "R9");
      @(negedge clk) active = 1'b0;
      @(negedge clk);
      expect_now(1'b0, 1'b0, "R9");
      @(negedge clk) active = 1'b1;
      expect_now(1'b0, 1'b0, "R9");
      run_word(8'h96, 0, 2, 2'b11, 8, "R9");
      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #1_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule